// File: doc/BRIEF.md
# Chip-Select-Gated Address Parity Checker

This block guards the address and command bus of a registered memory buffer against transfer errors. At each rising clock edge it takes the address and command bits, reduces them to a single parity bit, and keeps that bit for one cycle. It also keeps a flag that records whether any chip select was active in that cycle. At the next edge the host delivers its own parity bit for those bits. The block compares the two, and only when the stored flag shows an active chip select.

A disagreement pulls the active-low error output down. The output stays down for a fixed number of cycles, and each new disagreement during that time starts the count again. The error output stands for an open-drain pin: high means released and low means driven. Chip-select, clock-enable and on-die-termination signals are not part of the parity. Chip selects only enable the check, and the other control signals do not reach this block.

Top module: `csg_parity_check`

## Requirements
- R1: The computed parity is the XOR of all `ADDR_W` bits of `addr_cmd`, which equals the least significant bit of their arithmetic sum. Even parity gives 0 and odd parity gives 1.
- R2: The host parity bit for the bits sampled at rising edge k is the `par_in` value sampled at rising edge k+1.
- R3: If the stored parity differs from `par_in` at edge k+1 and the check is enabled, `err_n` is 0 right after edge k+1.
- R4: If the stored parity matches `par_in`, `err_n` stays at 1 when no hold is running.
- R5: A cycle in which every `cs_n` bit is 1 is not checked. A wrong `par_in` one edge later leaves `err_n` at 1.
- R6: Chip selects are active low. Any single `cs_n` bit at 0, the others at 1, enables the check for that cycle.
- R7: After a detected mismatch, `err_n` stays 0 for exactly `HOLD` edges (default 2) and then returns to 1.
- R8: A mismatch detected while `err_n` is already 0 restarts the count at `HOLD`.
- R9: While `rst_n` is 0, `err_n` is 1. The stored parity and enable flag are cleared, so the first compare after reset cannot flag an error, whatever `par_in` is.
- R10: `ADDR_W` defaults to 22 and `CS_W` to 4. Bit 21 of `addr_cmd` takes part in the parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_cmd | input | ADDR_W | Address and command bits covered by parity |
| cs_n | input | CS_W | Active-low chip selects that enable the check |
| par_in | input | 1 | Host parity, one cycle behind `addr_cmd` |
| err_n | output | 1 | Active-low error, 1 when released |

## Verification
Two events can fall in the same cycle: a new mismatch, and the countdown of a hold that is already running. The bench forces this by placing a second wrong parity bit one cycle after the first. The output must then stay low for a full `HOLD` cycles counted from the second mismatch, not from the first. A gated-off cycle is also placed right after an active one. This checks that the enable flag travels with its own parity bit and does not lag behind it.

// File: rtl/csg_pkg.sv
package csg_pkg;

  typedef enum logic {
    ERR_DRIVEN   = 1'b0,
    ERR_RELEASED = 1'b1
  } err_lvl_e;

  // bits needed to hold the value n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/csg_xor_tree.sv
module csg_xor_tree #(
  parameter int W   = 22,
  parameter int GRP = 4
) (
  input  logic [W-1:0] bits,
  output logic         par
);
  localparam int NGRP = (W + GRP - 1) / GRP;
  localparam int PW   = NGRP * GRP;

  logic [PW-1:0]   padded;
  logic [NGRP-1:0] grp_par;

  always_comb begin
    padded        = '0;
    padded[W-1:0] = bits;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_par[g] = ^padded[g*GRP +: GRP];
  end

  assign par = ^grp_par;
endmodule

// File: rtl/csg_capture.sv
module csg_capture #(
  parameter int ADDR_W = 22,
  parameter int CS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_cmd,
  input  logic [CS_W-1:0]   cs_n,
  output logic              par_q,
  output logic              gate_q
);
  logic par_now;

  csg_xor_tree #(.W(ADDR_W), .GRP(4)) u_tree (
    .bits (addr_cmd),
    .par  (par_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      par_q  <= par_now;
      gate_q <= ~&cs_n;
    end
  end
endmodule

// File: rtl/csg_err_hold.sv
module csg_err_hold
  import csg_pkg::*;
#(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  output logic err_n
);
  localparam int CW = cnt_bits(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (fault)     cnt <= CW'(HOLD);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  err_lvl_e lvl;
  assign lvl   = (cnt == '0) ? ERR_RELEASED : ERR_DRIVEN;
  assign err_n = lvl;
endmodule

// File: rtl/csg_parity_check.sv
module csg_parity_check #(
  parameter int ADDR_W = 22,
  parameter int CS_W   = 4,
  parameter int HOLD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_cmd,
  input  logic [CS_W-1:0]   cs_n,
  input  logic              par_in,
  output logic              err_n
);
  logic par_q, gate_q, fault;

  csg_capture #(.ADDR_W(ADDR_W), .CS_W(CS_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_cmd (addr_cmd),
    .cs_n     (cs_n),
    .par_q    (par_q),
    .gate_q   (gate_q)
  );

  assign fault = gate_q & (par_q ^ par_in);

  csg_err_hold #(.HOLD(HOLD)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .fault (fault),
    .err_n (err_n)
  );
endmodule

// File: rtl/csg_parity_check_chk.sv
module csg_parity_check_chk #(
  parameter int ADDR_W = 22,
  parameter int CS_W   = 4,
  parameter int HOLD   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_cmd,
  input logic [CS_W-1:0]   cs_n,
  input logic              par_in,
  input logic              err_n
);
  localparam int CW = csg_pkg::cnt_bits(HOLD);

  logic          ref_par, ref_gate, mism;
  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_par  <= 1'b0;
      ref_gate <= 1'b0;
    end else begin
      ref_par  <= ^addr_cmd;
      ref_gate <= (cs_n != {CS_W{1'b1}});
    end
  end

  assign mism = ref_gate && (ref_par != par_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since <= CW'(HOLD);
    else if (mism)              since <= CW'(1);
    else if (since < CW'(HOLD)) since <= since + 1'b1;
  end

  // R3
  mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mism |=> !err_n);

  // R4
  match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_n && !mism) |=> err_n);

  // R5
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_n && !ref_gate) |=> err_n);

  // R7
  hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> !err_n);

  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since == CW'(HOLD) && !mism) |=> err_n);

  // R9
  reset_release_chk: assert property (@(posedge clk)
    !rst_n |-> err_n);
endmodule

bind csg_parity_check csg_parity_check_chk #(
  .ADDR_W (ADDR_W),
  .CS_W   (CS_W),
  .HOLD   (HOLD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr_cmd (addr_cmd),
  .cs_n     (cs_n),
  .par_in   (par_in),
  .err_n    (err_n)
);

// File: tb/csg_parity_check_bench.sv
module csg_parity_check_bench;
  localparam int ADDR_W = 22;
  localparam int CS_W   = 4;
  localparam int HOLD   = 2;
  localparam logic [CS_W-1:0] ACT  = 4'b1110;
  localparam logic [CS_W-1:0] IDLE = 4'b1111;

  logic clk = 1'b0;
  logic rst_n;
  logic [ADDR_W-1:0] addr_cmd;
  logic [CS_W-1:0]   cs_n;
  logic par_in;
  logic err_n;

  always #10 clk = ~clk;

  csg_parity_check #(.ADDR_W(ADDR_W), .CS_W(CS_W), .HOLD(HOLD)) u_csg_parity_check (
    .clk(clk), .rst_n(rst_n), .addr_cmd(addr_cmd), .cs_n(cs_n),
    .par_in(par_in), .err_n(err_n)
  );

  typedef struct { logic exp; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [ADDR_W-1:0] prev_a;
  logic prev_gate;
  int   hcnt;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: err_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic good();
    return ^prev_a;
  endfunction

  // driver: applies one cycle and queues the expected err_n after the next edge
  task automatic step(input logic [ADDR_W-1:0] a, input logic [CS_W-1:0] cs,
                      input logic p, input string tag);
    logic mism;
    @(negedge clk);
    addr_cmd = a; cs_n = cs; par_in = p;
    mism = prev_gate && ((^prev_a) != p);
    if (mism) hcnt = HOLD;
    else if (hcnt > 0) hcnt--;
    q.push_back('{exp: (hcnt == 0), tag: tag});
    prev_a = a;
    prev_gate = (cs != IDLE);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(err_n, e.exp, e.tag);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    addr_cmd = 22'h000001; cs_n = 4'b0000; par_in = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(err_n, 1'b1, "R9 in reset");
    // release with wrong parity and an active select already present
    rst_n = 1'b1;
    prev_a = '0; prev_gate = 1'b0; hcnt = 0;
    q.push_back('{exp: 1'b1, tag: "R9 first compare"});
    prev_a = addr_cmd; prev_gate = 1'b1;
    step(22'h000000, ACT, good(), "R9 settle");

    // R4: correct parity on varied patterns
    step(22'h3FFFFF, ACT, good(), "R4");
    step(22'h2AAAAA, ACT, good(), "R4");
    step(22'h155555, ACT, good(), "R4");
    step(22'h000001, ACT, good(), "R4");
    step(22'h000000, ACT, good(), "R4");

    // R1 / R10: each single bit, correct then wrong parity
    for (int i = 0; i < ADDR_W; i++) begin
      step(ADDR_W'(1) << i, ACT, good(), "R1 setup");
      step(22'h000000, ACT, ~good(), (i == ADDR_W-1) ? "R10 bit21" : "R1 bit");
      step(22'h000000, ACT, good(), "R7 hold");
      step(22'h000000, ACT, good(), "R7 release");
    end

    // R3 / R7: single mismatch then clean cycles
    step(22'h0F0F0F, ACT, good(), "R3 setup");
    step(22'h000000, ACT, ~good(), "R3");
    step(22'h000000, ACT, good(), "R7 low");
    step(22'h000000, ACT, good(), "R7 high");
    step(22'h000000, ACT, good(), "R7 high");

    // R8: back-to-back mismatches restart the hold
    step(22'h000000, ACT, ~good(), "R8 first");
    step(22'h000000, ACT, ~good(), "R8 second");
    step(22'h000000, ACT, good(), "R8 extended");
    step(22'h000000, ACT, good(), "R8 release");
    step(22'h000000, ACT, good(), "R8 quiet");

    // R5: unselected cycle with wrong parity afterwards
    step(22'h000007, IDLE, good(), "R5 setup");
    step(22'h000000, ACT, ~good(), "R5");
    step(22'h000000, ACT, good(), "R5 quiet");

    // R6: each select bit alone enables the check
    for (int j = 0; j < CS_W; j++) begin
      step(22'h000003, ~(CS_W'(1) << j), good(), "R6 setup");
      step(22'h000000, IDLE, ~good(), "R6");
      step(22'h000000, IDLE, good(), "R6 hold");
      step(22'h000000, IDLE, good(), "R6 release");
    end

    // R2: parity for the current word instead of the previous one is wrong
    step(22'h000001, ACT, good(), "R2 setup");
    step(22'h000000, ACT, 1'b0, "R2 lag");
    step(22'h000000, ACT, good(), "R2 hold");
    step(22'h000000, ACT, good(), "R2 release");

    // mixed traffic
    for (int k = 0; k < 60; k++) begin
      logic [ADDR_W-1:0] a;
      logic [CS_W-1:0] c;
      a = ADDR_W'($urandom);
      c = (k % 3 == 0) ? IDLE : CS_W'($urandom);
      step(a, c, (k % 5 == 0) ? ~good() : good(), "R1 mixed");
    end

    step(22'h000000, IDLE, good(), "R4 drain");
    step(22'h000000, IDLE, good(), "R4 drain");
    step(22'h000000, IDLE, good(), "R4 drain");
    @(posedge clk); #6;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule